// File: doc/BRIEF.md
# Timer Time-Base Prescaler and Divided Clock Output

This block holds one 8-bit clock-control register and derives two things from it. The first is a single-cycle tick enable shared by the timers and the watchdog, produced by a reloading 4-bit down-counter. Its division ratio is programmable from 1 to 16, so the timers can count every cycle or at a slower rate such as once every 12 cycles.

The second is a divided copy of the system clock, meant to be routed to a pin. The divider selects f/2, f/4, f/8 or f/16. It runs only when software enables it and the active clock source allows an output clock, meaning an internal RC oscillator or an external clock rather than a crystal.

Software writes and reads the register through a plain write strobe and a read data bus. The timers and the pin multiplexer sit outside and consume `tick`, `clk_out` and `clk_out_en`.

Top module: `tbase_clkout_ctrl`

## Requirements
- R1: The register resets to 0x00. Bits 7:4 hold the prescale setting P, bits 2:1 the divider select S and bit 0 the output enable E. Bit 3 is not stored and always reads 0. A write takes effect at its clock edge, and `rd_data` then shows the written value with bit 3 cleared.
- R2: With setting P, `tick` is high for one cycle out of every P+1. The internal counter never exceeds P.
- R3: With P = 0, `tick` is high in every cycle, including the cycles right after reset.
- R4: With P = 11, `tick` is high exactly once every 12 cycles.
- R5: Every register write restarts the prescaler from the newly written P. Counting the cycle after the write edge as cycle 0, `tick` is high in cycle k exactly when k mod (P+1) = P.
- R6: While the output is active, `clk_out` equals bit S of a 4-bit phase counter. That counter is 0 in the first active cycle and advances by one per active cycle. The result is S=00 → f/2, 01 → f/4, 10 → f/8 and 11 → f/16, with the low half of each period coming first.
- R7: `clk_out_en` is high exactly when E = 1 and `src_ok` = 1.
- R8: While `clk_out_en` is low, `clk_out` is low and the phase counter is held at zero, so the next activation restarts the output phase.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| wr_en | input | 1 | Register write strobe |
| wr_data | input | 8 | Register write data |
| rd_data | output | 8 | Register read value |
| src_ok | input | 1 | High when the current clock source permits a clock output |
| tick | output | 1 | Time-base enable for timers and watchdog |
| clk_out | output | 1 | Divided system clock |
| clk_out_en | output | 1 | Clock output active, for the pin multiplexer |

## Verification
A wrong prescaler count shows up as a `tick` in the wrong cycle, within at most 16 cycles. A write that fails to reload the counter gives a first tick at the wrong offset after the write. A phase counter that drifts or fails to clear appears on `clk_out` within one output period, or in the first cycles after the output is re-enabled. A corrupted register field shows up on `rd_data` in the cycle after the write.

// File: rtl/ckc_pkg.sv
package ckc_pkg;
  localparam int PRE_W  = 4;
  localparam int SEL_W  = 2;
  localparam int PH_W   = 1 << SEL_W;
  localparam int REG_W  = 8;
  localparam int PRE_LSB = 4;
  localparam int SEL_LSB = 1;
  localparam int EN_BIT  = 0;

  typedef struct packed {
    logic [PRE_W-1:0] pre;
    logic [SEL_W-1:0] sel;
    logic             oen;
  } ckc_cfg_t;
endpackage

// File: rtl/ckc_cfg_reg.sv
module ckc_cfg_reg
  import ckc_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [REG_W-1:0] wr_data,
  output ckc_cfg_t         cfg,
  output logic [REG_W-1:0] rd_data
);
  ckc_cfg_t cfg_q, cfg_d;

  always_comb begin
    cfg_d = cfg_q;
    if (wr_en) begin
      cfg_d.pre = wr_data[PRE_LSB +: PRE_W];
      cfg_d.sel = wr_data[SEL_LSB +: SEL_W];
      cfg_d.oen = wr_data[EN_BIT];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cfg_q <= '0;
    else        cfg_q <= cfg_d;
  end

  always_comb begin
    rd_data = '0;
    rd_data[PRE_LSB +: PRE_W] = cfg_q.pre;
    rd_data[SEL_LSB +: SEL_W] = cfg_q.sel;
    rd_data[EN_BIT]           = cfg_q.oen;
  end

  assign cfg = cfg_q;

  // R1: written fields reappear, unused bit reads zero
  p_write_readback_r1: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> rd_data == {$past(wr_data[7:4]), 1'b0, $past(wr_data[2:0])});
endmodule

// File: rtl/ckc_prescaler.sv
module ckc_prescaler
  import ckc_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [PRE_W-1:0] load_val,
  input  logic [PRE_W-1:0] pre,
  output logic             tick
);
  logic [PRE_W-1:0] cnt_q, cnt_d;

  always_comb begin
    if (load)             cnt_d = load_val;
    else if (cnt_q == '0) cnt_d = pre;
    else                  cnt_d = cnt_q - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign tick = (cnt_q == '0);

  // R2: counter stays within the programmed setting
  p_cnt_bounded_r2: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= pre);
  // R2: after a tick without a write the counter restarts from the setting
  p_wrap_reload_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && !load) |=> cnt_q == $past(pre));
  // R3: divide-by-one ticks every cycle
  p_div1_every_cycle_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (pre == '0) |-> tick);
  // R5: a write restarts the count from the new setting
  p_write_restart_r5: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> cnt_q == $past(load_val));
endmodule

// File: rtl/ckc_clkout_div.sv
module ckc_clkout_div
  import ckc_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic [SEL_W-1:0] sel,
  output logic             clk_out
);
  logic [PH_W-1:0] ph_q, ph_d;

  always_comb begin
    if (run) ph_d = ph_q + 1'b1;
    else     ph_d = '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ph_q <= '0;
    else        ph_q <= ph_d;
  end

  assign clk_out = run & ph_q[sel];

  // R6: phase advances by one in each active cycle
  p_phase_step_r6: assert property (@(posedge clk) disable iff (!rst_n)
    run |=> ph_q == PH_W'($past(ph_q) + 1'b1));
  // R8: an inactive cycle clears the phase
  p_phase_clear_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !run |=> ph_q == '0);
  // R8: output is low whenever the output is inactive
  p_out_low_off_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !run |-> !clk_out);
endmodule

// File: rtl/tbase_clkout_ctrl.sv
module tbase_clkout_ctrl
  import ckc_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       wr_en,
  input  logic [7:0] wr_data,
  output logic [7:0] rd_data,
  input  logic       src_ok,
  output logic       tick,
  output logic       clk_out,
  output logic       clk_out_en
);
  logic [1:0] rst_sync_q;
  logic       rst_int_n;
  ckc_cfg_t   cfg;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= '0;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_int_n = rst_sync_q[1];

  ckc_cfg_reg u_reg (
    .clk     (clk),
    .rst_n   (rst_int_n),
    .wr_en   (wr_en),
    .wr_data (wr_data),
    .cfg     (cfg),
    .rd_data (rd_data)
  );

  ckc_prescaler u_pre (
    .clk      (clk),
    .rst_n    (rst_int_n),
    .load     (wr_en),
    .load_val (wr_data[PRE_LSB +: PRE_W]),
    .pre      (cfg.pre),
    .tick     (tick)
  );

  assign clk_out_en = cfg.oen & src_ok;

  ckc_clkout_div u_div (
    .clk     (clk),
    .rst_n   (rst_int_n),
    .run     (clk_out_en),
    .sel     (cfg.sel),
    .clk_out (clk_out)
  );

  // R7: output enable follows both the register bit and the source permission
  p_en_needs_src_r7: assert property (@(posedge clk) disable iff (!rst_int_n)
    clk_out_en |-> (src_ok && rd_data[0]));
endmodule

// File: tb/tbase_clkout_ctrl_test.sv
module tbase_clkout_ctrl_test;
  logic       clk = 1'b0;
  logic       rst_n;
  logic       wr_en;
  logic [7:0] wr_data;
  logic [7:0] rd_data;
  logic       src_ok;
  logic       tick, clk_out, clk_out_en;

  int n_chk = 0;
  int n_bad = 0;
  bit done  = 1'b0;

  logic [3:0] m_pre;
  logic [1:0] m_sel;
  logic       m_oen;
  int         m_k;
  logic [3:0] m_ph;

  always #2 clk = ~clk;

  tbase_clkout_ctrl uut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
    .rd_data(rd_data), .src_ok(src_ok), .tick(tick),
    .clk_out(clk_out), .clk_out_en(clk_out_en)
  );

  function automatic logic exp_tick(int k, logic [3:0] p);
    return (k % (int'(p) + 1)) == int'(p);
  endfunction

  function automatic logic [7:0] exp_reg(logic [3:0] p, logic [1:0] s, logic e);
    return {p, 1'b0, s, e};
  endfunction

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic step(input string tag);
    logic en_now;
    #1;
    en_now = m_oen && src_ok;
    chk(tag, {7'd0, tick}, {7'd0, exp_tick(m_k, m_pre)});
    chk("R7", {7'd0, clk_out_en}, {7'd0, en_now});
    chk(en_now ? "R6" : "R8", {7'd0, clk_out}, {7'd0, en_now && m_ph[m_sel]});
    chk("R1", rd_data, exp_reg(m_pre, m_sel, m_oen));
    @(posedge clk);
    m_ph = en_now ? m_ph + 4'd1 : 4'd0;
    if (wr_en) begin
      m_k   = 0;
      m_pre = wr_data[7:4];
      m_sel = wr_data[2:1];
      m_oen = wr_data[0];
    end else begin
      m_k++;
    end
    #1;
  endtask

  task automatic wr(input logic [7:0] d, input string tag);
    wr_en = 1'b1; wr_data = d;
    step(tag);
    wr_en = 1'b0; wr_data = $urandom;
  endtask

  task automatic run(input int n, input string tag);
    for (int i = 0; i < n; i++) step(tag);
  endtask

  initial begin
    #800000;
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd4711));
    rst_n = 1'b0; wr_en = 1'b0; wr_data = 8'h00; src_ok = 1'b0;
    m_pre = '0; m_sel = '0; m_oen = 1'b0; m_k = 0; m_ph = '0;
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;
    repeat (4) @(posedge clk);
    #1;
    // R1 and R3: reset state, divide-by-one ticks immediately
    run(4, "R3");
    src_ok = 1'b1;
    wr(8'b0000_0001, "R5");   // P=0, f/2, output on
    run(20, "R3");
    wr(8'b1011_0011, "R5");   // P=11, f/4
    run(40, "R4");
    wr(8'b1111_0111, "R5");   // P=15, f/16
    run(40, "R2");
    wr(8'b0101_1101, "R5");   // P=5, bit 3 set must read 0, f/8
    run(3, "R5");
    wr(8'b0101_0101, "R5");   // rewrite same P mid-count: restart
    run(20, "R5");
    src_ok = 1'b0;            // source forbids output
    run(10, "R8");
    src_ok = 1'b1;            // phase restarts
    run(20, "R6");
    wr(8'b0010_0110, "R5");   // output enable cleared
    run(10, "R8");
    wr(8'b0000_0001, "R5");
    run(8, "R3");
    for (int i = 0; i < 3000; i++) begin
      if ($urandom % 32 == 0) src_ok = ~src_ok;
      if ($urandom % 16 == 0) wr(8'($urandom), "R5");
      else step("R2");
    end
    done = 1'b1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule